// File: doc/BRIEF.md
# Scannable Hysteresis Threshold Gate

This block models an m-of-n threshold gate with hysteresis, of the kind used as the basic element of dual-rail self-timed logic. The output rises as soon as at least `M` of the `N` inputs are high. Once high it stays high while any input remains high, and it falls only when every input is low. When neither the rising nor the falling condition holds, the output keeps its last value. The gate therefore computes `z = set | (any & prev)`, where `set` means "at least M inputs high", `any` means "at least one input high" and `prev` is the stored output.

The stored `prev` term does not come from a combinational loop. It comes from a clocked feedback cell that can also be a stage of a scan chain. In functional mode the cell passes the gate output back, which makes it behave like a buffer in the feedback path. In test mode it can either capture the gate output or shift a value in from `scan_in`. Its content is always visible on `scan_out`. This lets an external tester load and observe the hysteresis state. A gate with `M = 1` reduces to an OR of its inputs and needs no feedback, so that variant has no cell and passes `scan_in` straight to `scan_out`.

Top module: `scan_thgate`

## Requirements
- R1: While `rst` is high at a rising clock edge, the feedback state is cleared to 0. After reset, `scan_out` is 0 and, with all inputs low, `z` is 0.
- R2: Whenever at least `M` bits of `in_bits` are 1, `z` is 1 in the same cycle, whatever the stored state.
- R3: Once `z` is 1 and the state has captured it, `z` stays 1 for as long as at least one bit of `in_bits` is 1, even when fewer than `M` bits are 1.
- R4: Whenever all bits of `in_bits` are 0, `z` is 0.
- R5: When the stored state is 0 and between 1 and `M-1` bits of `in_bits` are 1, `z` stays 0.
- R6: With `test_mode`=1 and `shift_en`=1, each rising edge loads `scan_in` into the feedback state. `scan_out` shows the loaded value, and `z` uses it as the previous output.
- R7: With `test_mode`=1 and `shift_en`=0, each rising edge captures the present `z` into the feedback state, where it becomes visible on `scan_out`.
- R8: With `test_mode`=0, `shift_en` and `scan_in` have no effect. Each rising edge captures `z` into the state.
- R9: With `M`=1, `z` is the OR of `in_bits`, and `scan_out` equals `scan_in` in the same cycle, because there is no feedback cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the feedback cell |
| rst | input | 1 | Synchronous active-high reset of the feedback state |
| in_bits | input | N | Single-rail gate inputs |
| test_mode | input | 1 | 1 selects test mode for the feedback cell |
| shift_en | input | 1 | In test mode, 1 shifts `scan_in` into the cell; 0 captures `z` |
| scan_in | input | 1 | Serial scan data in |
| scan_out | output | 1 | Feedback state, which is the serial scan data out |
| z | output | 1 | Gate output |

## Verification
A wrong feedback state appears at `z` in the first cycle in which the input count lies between 1 and `M-1`: a lost hold lets the output drop early, and a stale 1 keeps it high. The same state is visible on `scan_out` one edge after the capture or shift that set it. The bench therefore walks the gate through set, partial release, full release and sub-threshold patterns, and checks `z` in each cycle. It also shifts known values in and reads them back, which confirms that the loaded state drives the hysteresis term.

// File: rtl/thg_pkg.sv
package thg_pkg;

    typedef enum logic [1:0] {
        FB_FUNC    = 2'd0,
        FB_CAPTURE = 2'd1,
        FB_SHIFT   = 2'd2
    } fb_mode_e;

    typedef struct packed {
        logic set_hit;
        logic any_hit;
    } thr_terms_t;

    function automatic fb_mode_e decode_mode(input logic test_mode, input logic shift_en);
        if (!test_mode)
            return FB_FUNC;
        else if (shift_en)
            return FB_SHIFT;
        else
            return FB_CAPTURE;
    endfunction

    function automatic logic combine_terms(input thr_terms_t t, input logic prev_z);
        return t.set_hit | (t.any_hit & prev_z);
    endfunction

endpackage

// File: rtl/thg_term_eval.sv
module thg_term_eval
    import thg_pkg::*;
#(
    parameter int M = 2,
    parameter int N = 3
) (
    input  logic [N-1:0] in_bits,
    output thr_terms_t   terms,
    output logic [$clog2(N+1)-1:0] count
);
    localparam int CW = $clog2(N+1);

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            count = count + CW'(in_bits[i]);
        end
    end

    always_comb begin
        terms.set_hit = (count >= CW'(M));
        terms.any_hit = |in_bits;
    end
endmodule

// File: rtl/thg_fb_cell.sv
module thg_fb_cell
    import thg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  fb_mode_e mode,
    input  logic     d_z,
    input  logic     scan_in,
    output logic     q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= 1'b0;
        end else begin
            case (mode)
                FB_SHIFT: q <= scan_in;
                default:  q <= d_z;
            endcase
        end
    end

    p_shift_load_r6: assert property (@(posedge clk) disable iff (rst)
        (mode == FB_SHIFT) |=> (q == $past(scan_in)));

    p_capture_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == FB_CAPTURE) |=> (q == $past(d_z)));

    p_func_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (mode == FB_FUNC) |=> (q == $past(d_z)));
endmodule

// File: rtl/scan_thgate.sv
module scan_thgate
    import thg_pkg::*;
#(
    parameter int M = 2,
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] in_bits,
    input  logic         test_mode,
    input  logic         shift_en,
    input  logic         scan_in,
    output logic         scan_out,
    output logic         z
);
    localparam int CW = $clog2(N+1);

    thr_terms_t    terms;
    logic [CW-1:0] count;

    thg_term_eval #(.M(M), .N(N)) u_eval (
        .in_bits (in_bits),
        .terms   (terms),
        .count   (count)
    );

    generate
        if (M > 1) begin : g_latched
            fb_mode_e mode;
            logic     prev_z;

            assign mode = decode_mode(test_mode, shift_en);

            thg_fb_cell u_cell (
                .clk     (clk),
                .rst     (rst),
                .mode    (mode),
                .d_z     (z),
                .scan_in (scan_in),
                .q       (prev_z)
            );

            assign z        = combine_terms(terms, prev_z);
            assign scan_out = prev_z;

            p_reset_clear_r1: assert property (@(posedge clk)
                rst |=> !scan_out);

            p_set_wins_r2: assert property (@(posedge clk) disable iff (rst)
                (count >= CW'(M)) |-> z);

            p_hold_r3: assert property (@(posedge clk) disable iff (rst)
                (z && (mode != FB_SHIFT)) ##1 (in_bits != '0) |-> z);

            p_release_r4: assert property (@(posedge clk) disable iff (rst)
                (in_bits == '0) |-> !z);

            p_below_r5: assert property (@(posedge clk) disable iff (rst)
                (!z && (mode != FB_SHIFT)) ##1 (count < CW'(M)) |-> !z);
        end else begin : g_or_only
            assign z        = terms.any_hit;
            assign scan_out = scan_in;
        end
    endgenerate
endmodule

// File: tb/sim_scan_thgate.sv
module sim_scan_thgate;
    localparam int  CLK_PERIOD = 10;
    localparam int  M = 2;
    localparam int  N = 3;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] in_bits = '0;
    logic         test_mode = 1'b0;
    logic         shift_en = 1'b0;
    logic         scan_in = 1'b0;
    logic         scan_out, z;

    logic [N-1:0] or_in = '0;
    logic         or_scan_in = 1'b0;
    logic         or_scan_out, or_z;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    logic model_q = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_thgate #(.M(M), .N(N)) u0 (
        .clk(clk), .rst(rst), .in_bits(in_bits), .test_mode(test_mode),
        .shift_en(shift_en), .scan_in(scan_in), .scan_out(scan_out), .z(z)
    );

    scan_thgate #(.M(1), .N(N)) u1 (
        .clk(clk), .rst(rst), .in_bits(or_in), .test_mode(test_mode),
        .shift_en(shift_en), .scan_in(or_scan_in), .scan_out(or_scan_out), .z(or_z)
    );

    function automatic logic model_z(input logic [N-1:0] v, input logic prev);
        int c = 0;
        for (int i = 0; i < N; i++) c += int'(v[i]);
        return (c >= M) | ((v != '0) & prev);
    endfunction

    task automatic check(input logic actual, input logic expected, input string req);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, actual, expected);
        end
    endtask

    task automatic tick();
        logic nxt;
        if (rst) nxt = 1'b0;
        else if (test_mode && shift_en) nxt = scan_in;
        else nxt = model_z(in_bits, model_q);
        @(posedge clk);
        model_q = nxt;
        @(negedge clk);
    endtask

    task automatic apply(input logic [N-1:0] v);
        in_bits = v;
        #1;
    endtask

    task automatic t_reset();
        rst = 1'b1; apply('0);
        tick(); tick();
        rst = 1'b0; #1;
        check(scan_out, 1'b0, "R1 scan_out after reset");
        check(z, 1'b0, "R1 z after reset");
    endtask

    task automatic t_set_patterns();
        logic [N-1:0] pats [4] = '{3'b110, 3'b011, 3'b101, 3'b111};
        for (int k = 0; k < 4; k++) begin
            apply('0); tick();
            apply(pats[k]);
            check(z, 1'b1, "R2 threshold met");
            check(z, model_z(in_bits, model_q), "R2 model");
        end
    endtask

    task automatic t_hold_release();
        apply(3'b110); tick();
        apply(3'b100);
        check(z, 1'b1, "R3 hold with one input");
        tick();
        apply(3'b001);
        check(z, 1'b1, "R3 hold after swap");
        tick();
        apply(3'b000);
        check(z, 1'b0, "R4 release when all low");
        tick();
    endtask

    task automatic t_below();
        apply(3'b000); tick();
        apply(3'b001);
        check(z, 1'b0, "R5 single input from null");
        tick();
        apply(3'b010);
        check(z, 1'b0, "R5 still below threshold");
        check(z, model_z(in_bits, model_q), "R5 model");
        apply(3'b000); tick();
    endtask

    task automatic t_shift();
        test_mode = 1'b1; shift_en = 1'b1;
        apply(3'b001);
        scan_in = 1'b1; tick();
        check(scan_out, 1'b1, "R6 shifted one visible");
        check(z, 1'b1, "R6 loaded state holds output");
        scan_in = 1'b0; tick();
        check(scan_out, 1'b0, "R6 shifted zero visible");
        check(z, 1'b0, "R6 loaded zero drops output");
        test_mode = 1'b0; shift_en = 1'b0;
        apply('0); tick();
    endtask

    task automatic t_capture();
        test_mode = 1'b1; shift_en = 1'b0; scan_in = 1'b0;
        apply(3'b110); tick();
        check(scan_out, 1'b1, "R7 captured one");
        apply(3'b001);
        check(z, 1'b1, "R7 captured state holds");
        apply(3'b000); tick();
        check(scan_out, 1'b0, "R7 captured zero");
        test_mode = 1'b0;
    endtask

    task automatic t_func_ignores_shift();
        test_mode = 1'b0; shift_en = 1'b1; scan_in = 1'b1;
        apply(3'b000); tick();
        check(scan_out, 1'b0, "R8 scan_in ignored in function mode");
        apply(3'b001);
        check(z, 1'b0, "R8 output unaffected by scan_in");
        shift_en = 1'b0; scan_in = 1'b0;
        apply('0); tick();
    endtask

    task automatic t_or_variant();
        or_in = 3'b000; or_scan_in = 1'b1; #1;
        check(or_z, 1'b0, "R9 or gate low");
        check(or_scan_out, 1'b1, "R9 scan passthrough one");
        or_in = 3'b010; or_scan_in = 1'b0; #1;
        check(or_z, 1'b1, "R9 or gate high");
        check(or_scan_out, 1'b0, "R9 scan passthrough zero");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=timeout expected=done");
                finish_run();
            end
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_patterns();
        t_hold_release();
        t_below();
        t_shift();
        t_capture();
        t_func_ignores_shift();
        t_or_variant();
        finish_run();
    end
endmodule